// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

A free-running watchdog counter behind a small single-cycle register bus. The bus has a select, a write enable, an address, a 32-bit write word and a combinational read word. Software sets up two independent timeouts, each a power of two of clock cycles. The shorter one acts as an early warning: when the count reaches it, a sticky interrupt flag is raised. The longer one, when armed, produces a one-cycle reset request for the system reset controller and records that event in a sticky flag.

The count is never restarted by a single write. Software must write the key byte 0xA5 to the feed register, then write 0x5A as the very next feed write. Any other feed value breaks the sequence. A shift parameter shortens every timeout by the same power of two, so that all sixteen codes can be exercised in a short run.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the control word reads as zero, `irq_o` is low and `rst_req_o` is low.
- R2: The control word is at byte address 0x00, with these fields: interrupt code in [3:0], reset code in [7:4], count enable at bit 8, interrupt flag at bit 9, interrupt enable at bit 10, reset enable at bit 11 and reset-occurred flag at bit 31. The bits [11:10], [8] and [7:0] read back as written. The feed register at 0x04, and every other address, reads as zero.
- R3: The internal count advances by one on each clock while bit 8 is 1 and holds while bit 8 is 0. At its all-ones value it stops.
- R4: Code n in [3:0] gives an interrupt timeout of 2^(31-SHIFT-n) cycles. Once the count has reached that value, bit 9 sets on the next clock. `irq_o` is bit 9 AND bit 10.
- R5: Writing 1 to bit 9 clears the interrupt flag. A new timeout hit in the same cycle wins over the clear.
- R6: Code m in [7:4] gives a reset timeout of 2^(31-SHIFT-m) cycles. When bit 11 is 1 and the count has reached that value, `rst_req_o` is high for exactly one cycle, bit 31 sets and the count restarts from zero.
- R7: Bit 31 is cleared only by writing 1 to it or by the block's own reset input. It survives further reset requests.
- R8: A feed write whose low byte is 0xA5, followed by a feed write whose low byte is 0x5A, clears the count to zero. Writes to other addresses in between do not break the sequence.
- R9: A feed write with any other low byte after 0xA5 abandons the sequence, and a later 0x5A then has no effect. A repeated 0xA5 keeps the sequence armed.
- R10: A change to [7:0] applies from the next clock and does not restart the count. If the new timeout is already at or below the count, the matching event fires at once.
- R11: With SHIFT set to 0, code 0 means 2^31 cycles and code 15 means 2^16 cycles. SHIFT may be at most 16.

Top module port order below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Bus select |
| we_i | input | 1 | Write enable (valid with sel_i) |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 1 | Early-warning interrupt |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The hardest cases to reach are the ones that depend on hidden count values. Examples are a timeout lowered beneath a count that is already running, and a broken key sequence, whose only visible sign is that a later reset request still arrives on time. The stimulus reaches them by letting the count run for known stretches, then issuing control and feed writes at chosen cycles. A behavioural model in the bench follows the count and compares the interrupt, the reset pulse and the control read-back on every clock. A separate run of 2^15 cycles covers code 0 at the largest timeout.

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int SHIFT  = 0,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int MAXE  = 31 - SHIFT;
  localparam int CNT_W = MAXE + 1;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_FEED = ADDR_W'(4);
  localparam logic [7:0] KEY_ARM = 8'hA5;
  localparam logic [7:0] KEY_GO  = 8'h5A;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [3:0]       icode_q, rcode_q;
  logic             en_q, ie_q, re_q, iflag_q, rflag_q, armed_q;
  logic [CNT_W-1:0] cnt_q;

  wire wr_ctrl   = sel_i && we_i && addr_i == A_CTRL;
  wire wr_feed   = sel_i && we_i && addr_i == A_FEED;
  wire feed_done = wr_feed && armed_q && wdata_i[7:0] == KEY_GO;
  wire unused_wd = ^wdata_i[30:12];

  wire [CNT_W-1:0] lim_i = ONE << (MAXE - int'(icode_q));
  wire [CNT_W-1:0] lim_r = ONE << (MAXE - int'(rcode_q));
  wire hit_i = cnt_q >= lim_i;
  wire hit_r = re_q && cnt_q >= lim_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      icode_q <= '0; rcode_q <= '0;
      en_q <= 1'b0; ie_q <= 1'b0; re_q <= 1'b0;
      iflag_q <= 1'b0; rflag_q <= 1'b0; armed_q <= 1'b0;
      cnt_q <= '0; rst_req_o <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        icode_q <= wdata_i[3:0];
        rcode_q <= wdata_i[7:4];
        en_q    <= wdata_i[8];
        ie_q    <= wdata_i[10];
        re_q    <= wdata_i[11];
      end
      iflag_q <= (iflag_q && !(wr_ctrl && wdata_i[9]))  || hit_i;
      rflag_q <= (rflag_q && !(wr_ctrl && wdata_i[31])) || hit_r;
      rst_req_o <= hit_r;
      if (wr_feed) armed_q <= (wdata_i[7:0] == KEY_ARM);
      if (feed_done || hit_r)     cnt_q <= '0;
      else if (en_q && ~&cnt_q)   cnt_q <= cnt_q + ONE;
    end
  end

  assign irq_o = iflag_q && ie_q;

  always_comb begin
    rdata_o = '0;
    if (sel_i && addr_i == A_CTRL)
      rdata_o = {rflag_q, 19'b0, re_q, ie_q, iflag_q, en_q, rcode_q, icode_q};
  end

  AST_RST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);  // R6
  AST_RST_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(re_q));  // R6
  AST_RST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> rflag_q);  // R7
  AST_FEED_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_feed && armed_q && wdata_i[7:0] == KEY_GO) |=> cnt_q == '0);  // R8
  AST_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !feed_done && !hit_r) |=> $stable(cnt_q));  // R3
  AST_IRQ_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rdata_o[9] || !(sel_i && addr_i == A_CTRL)));  // R4
endmodule

// File: tb/wdt_keyed_tb_top.sv
module wdt_keyed_tb_top;
  localparam int SH   = 16;
  localparam int MAXE = 31 - SH;
  localparam longint CMAX = (longint'(1) << (MAXE + 1)) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b1, we = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, rreq;

  always #4 clk = ~clk;

  wdt_keyed #(.SHIFT(SH), .ADDR_W(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .rst_req_o(rreq));

  longint m_cnt;
  int m_ic, m_rc;
  bit m_en, m_ie, m_re, m_if, m_rf, m_arm, m_rq, chk_on;
  int vecs = 0, bad = 0, cycles = 0;
  string req = "R1";

  always @(posedge clk) begin
    longint li, lr;
    bit hi, hr, wc, wf, fd;
    cycles++;
    if (!rst_n) begin
      m_cnt = 0; m_ic = 0; m_rc = 0; m_en = 0; m_ie = 0; m_re = 0;
      m_if = 0; m_rf = 0; m_arm = 0; m_rq = 0;
    end else begin
      li = longint'(1) << (MAXE - m_ic);
      lr = longint'(1) << (MAXE - m_rc);
      hi = m_cnt >= li;
      hr = m_re && m_cnt >= lr;
      wc = sel && we && addr == 4'd0;
      wf = sel && we && addr == 4'd4;
      fd = wf && m_arm && wdata[7:0] == 8'h5A;
      m_if = (m_if && !(wc && wdata[9])) || hi;
      m_rf = (m_rf && !(wc && wdata[31])) || hr;
      m_rq = hr;
      if (wf) m_arm = wdata[7:0] == 8'hA5;
      if (fd || hr) m_cnt = 0;
      else if (m_en && m_cnt < CMAX) m_cnt = m_cnt + 1;
      if (wc) begin
        m_ic = int'(wdata[3:0]); m_rc = int'(wdata[7:4]);
        m_en = wdata[8]; m_ie = wdata[10]; m_re = wdata[11];
      end
    end
  end

  always @(negedge clk) begin
    logic [31:0] exp_rd;
    if (chk_on) begin
      exp_rd = 32'd0;
      if (sel && addr == 4'd0)
        exp_rd = {m_rf, 19'b0, m_re, m_ie, m_if, m_en, 4'(m_rc), 4'(m_ic)};
      vecs++;
      if (irq !== (m_if && m_ie)) begin
        bad++; $display("FAIL %s irq_o=%b expected %b at cycle %0d", req, irq, m_if && m_ie, cycles);
      end
      if (rreq !== m_rq) begin
        bad++; $display("FAIL %s rst_req_o=%b expected %b at cycle %0d", req, rreq, m_rq, cycles);
      end
      if (rdata !== exp_rd) begin
        bad++; $display("FAIL %s rdata_o=%h expected %h at cycle %0d", req, rdata, exp_rd, cycles);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1; sel = 1'b1; we = 1'b0; addr = 4'd0; wdata = '0;
    end
  endtask
  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); #1; sel = 1'b1; we = 1'b1; addr = a; wdata = d;
  endtask
  task automatic rd(logic [3:0] a);
    @(negedge clk); #1; sel = 1'b1; we = 1'b0; addr = a; wdata = '0;
  endtask
  task automatic feed();
    wr(4'd4, 32'hA5); wr(4'd4, 32'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); chk_on = 1'b1;
    req = "R1"; idle(4);
    req = "R2"; wr(4'd0, 32'h0000_04F3); rd(4'd0); rd(4'd4); rd(4'd8); rd(4'd12); idle(2);
    wr(4'd0, 32'h0); idle(2);
    req = "R4"; wr(4'd0, 32'h0000_050C); idle(20);
    req = "R5"; feed(); wr(4'd0, 32'h0000_070C); idle(20);
    req = "R3"; feed(); wr(4'd0, 32'h0000_020C); idle(40); wr(4'd0, 32'h0000_050C); idle(12);
    req = "R6"; feed(); wr(4'd0, 32'h0000_0DDF); idle(30);
    req = "R7"; wr(4'd0, 32'h8000_02DF); idle(3); wr(4'd0, 32'h8000_0000); idle(4);
    req = "R8"; wr(4'd0, 32'h0000_0FAC); idle(10); feed(); idle(20); wr(4'd4, 32'hA5); rd(4'd8);
    wr(4'd4, 32'h5A); idle(20); feed(); idle(20);
    req = "R9"; wr(4'd4, 32'hA5); wr(4'd4, 32'h00); wr(4'd4, 32'h5A); idle(40);
    wr(4'd4, 32'hA5); wr(4'd4, 32'hA5); wr(4'd4, 32'h5A); idle(10);
    wr(4'd4, 32'h15A); idle(30);
    req = "R10"; wr(4'd0, 32'h0000_0000); feed(); wr(4'd0, 32'h0000_0508); idle(60);
    wr(4'd0, 32'h0000_070B); idle(5); wr(4'd0, 32'h0000_08A8); idle(3); wr(4'd0, 32'h0000_0DA8); idle(20);
    req = "R11"; wr(4'd0, 32'h0000_0000); feed(); wr(4'd0, 32'h0000_0D0F); idle(8);
    wr(4'd0, 32'h0000_0500); feed(); idle(32800);
    req = "R3"; wr(4'd0, 32'h0000_0700); idle(5);
    print_end();
  end

  task automatic print_end();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired: cycles=%0d expected completion", cycles);
    print_end();
  end
endmodule